// File: doc/BRIEF.md
# SPI Target Serial Front End

This block is the serial edge of an SPI target (slave) device. It runs entirely in the system clock domain: the SPI clock, the select line and the controller-to-target data line pass through two-flop synchronizers. SPI clock edges are found by comparing successive synchronized samples, so the SPI clock is never used as a clock. Bits are shifted most significant bit first, in both directions at once. Each completed received byte leaves on a one-cycle strobe. The byte to send is taken from a one-entry holding register that the next stage fills through a valid/ready handshake. Clock polarity and phase are fixed by parameters before synthesis.

The receive stream has no back-pressure: the SPI controller sets the pace, so `rx_data` is valid only in the cycle `rx_valid` is high and must be taken then. The transmit stream does have back-pressure. `tx_ready` is high while the holding register is empty, and a byte moves on a clock edge where `tx_valid` and `tx_ready` are both high. While `tx_ready` is low, `tx_valid` is ignored. If a byte starts and the holding register is empty, 0x00 is sent.

Deselecting the target is a full reset of the serial engine. It clears the bit count, both shift registers and the holding register. It discards any partial byte, and it pulses `frame_end`. Selecting the target pulses `frame_start`. Decoding of what the bytes mean is left to the next stage.

Top module: `spi_target_frontend`

## Requirements
- R1: After every eighth sampling edge since select fell, `rx_valid` is high for exactly one cycle, and `rx_data` then holds the eight sampled bits with the first-sampled bit at bit 7.
- R2: Transmit runs in full duplex with receive and sends bit 7 first. Each byte of a frame is taken from the holding register when that byte starts, which empties the register.
- R3: Parameter CPOL sets the idle SPI clock level (0 = low, 1 = high); the leading edge is the first transition away from idle. With CPHA=0 the target samples on leading edges and changes `miso_o` on trailing edges. With CPHA=1 it changes `miso_o` on leading edges and samples on trailing edges. All four combinations work.
- R4: With CPHA=0, bit 7 of the first transmit byte is on `miso_o` within three clock cycles of select falling, before any SPI clock edge.
- R5: `tx_ready` is high exactly when the holding register is empty. While `tx_ready` is low, a `tx_valid` byte is not taken and the held byte is the one sent.
- R6: If a byte starts while the holding register is empty, that byte is sent as 0x00.
- R7: `miso_oe` is high only while the target is selected and is low whenever select is high, so the line is released.
- R8: `frame_start` pulses for one cycle after select falls, and `frame_end` pulses for one cycle after select rises.
- R9: Select rising aborts the frame: a partial byte produces no `rx_valid`, and the next frame starts at bit 7. A byte left in the holding register is dropped, so the next frame sends 0x00 unless a new byte is loaded.
- R10: Bytes are received correctly with an SPI clock at one quarter of the system clock, with each SPI clock level held for at least two cycles.
- R11: While reset is asserted and after it is released: `rx_valid`, `miso_oe`, `frame_start` and `frame_end` are low, and `tx_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| spi_clk | input | 1 | SPI clock from the controller (asynchronous) |
| spi_sel_n | input | 1 | Target select, active low (asynchronous) |
| spi_mosi | input | 1 | Serial data from the controller |
| miso_o | output | 1 | Serial data value toward the controller |
| miso_oe | output | 1 | Output enable for the data line; low means high impedance |
| rx_valid | output | 1 | One-cycle strobe for a received byte |
| rx_data | output | DATA_W | Received byte |
| tx_valid | input | 1 | Next transmit byte offered |
| tx_ready | output | 1 | Holding register empty; offer accepted |
| tx_data | input | DATA_W | Next transmit byte |
| frame_start | output | 1 | One-cycle pulse when select falls |
| frame_end | output | 1 | One-cycle pulse when select rises |

## Verification
The bench drives each of the four clock modes with two-byte frames and checks both directions. A design with a swapped sample or drive edge returns bytes shifted by one bit. A design that loads the first transmit byte late under CPHA=0 loses its top bit. Further frames cover three cases:
- An empty holding register at a byte boundary, which a faulty design fills with stale data instead of 0x00.
- A byte offered while `tx_ready` is low, which a faulty design takes, overwriting the held byte.
- A frame aborted after three bits. A design that keeps its bit count or its holding register emits a misaligned byte or stale data in the following frame.

A last frame runs at the quarter-rate SPI clock, where a slower edge detector drops bits.

// File: rtl/spi_fe_pkg.sv
package spi_fe_pkg;
  localparam int SYNC_STAGES = 2;

  typedef enum logic [1:0] {
    MODE_LOW_LEAD  = 2'b00,
    MODE_LOW_TRAIL = 2'b01,
    MODE_HIGH_LEAD = 2'b10,
    MODE_HIGH_TRAIL = 2'b11
  } spi_mode_e;
endpackage

// File: rtl/spi_fe_sync.sv
module spi_fe_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[s] <= RST_VAL;
      else if (s == 0) chain[s] <= d;
      else chain[s] <= chain[(s == 0) ? 0 : s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/spi_fe_txbuf.sv
module spi_fe_txbuf #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_valid,
  input  logic [DATA_W-1:0] tx_data,
  output logic              tx_ready,
  input  logic              consume,
  input  logic              clear,
  output logic              hold_full,
  output logic [DATA_W-1:0] hold_data
);
  logic              full_q;
  logic [DATA_W-1:0] data_q;
  logic              accept;

  assign accept    = tx_valid && !full_q;
  assign tx_ready  = !full_q;
  assign hold_full = full_q;
  assign hold_data = data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else begin
      if (clear) full_q <= 1'b0;
      else if (accept) full_q <= 1'b1;
      else if (consume) full_q <= 1'b0;
      if (accept && !clear) data_q <= tx_data;
    end
  end

  assert_busy_keeps_byte_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> $stable(hold_data));

  assert_consume_empties_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (consume && !clear) |=> !full_q);
endmodule

// File: rtl/spi_fe_shifter.sv
module spi_fe_shifter #(
  parameter int DATA_W = 8,
  parameter bit CPOL = 1'b0,
  parameter bit CPHA = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_s,
  input  logic              csn_s,
  input  logic              mosi_s,
  input  logic              hold_full,
  input  logic [DATA_W-1:0] hold_data,
  output logic              consume,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data,
  output logic              so_o,
  output logic              so_oe,
  output logic              frame_start,
  output logic              frame_end
);
  localparam int CW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CW-1:0] LAST = CW'(DATA_W - 1);

  logic              sclk_q, csn_q;
  logic [CW-1:0]     cnt_q;
  logic [DATA_W-1:0] rx_sh, tx_sh, rx_data_q, rx_next, next_tx;
  logic              rx_valid_q, so_oe_q, fs_q, fe_q;
  logic              rise, fall, lead_e, trail_e, sample_e, drive_e;
  logic              sel, cs_fall, cs_rise, load_req;

  always_comb begin
    rise     = sclk_s && !sclk_q;
    fall     = !sclk_s && sclk_q;
    lead_e   = CPOL ? fall : rise;
    trail_e  = CPOL ? rise : fall;
    sample_e = CPHA ? trail_e : lead_e;
    drive_e  = CPHA ? lead_e : trail_e;
    sel      = !csn_s;
    cs_fall  = csn_q && !csn_s;
    cs_rise  = !csn_q && csn_s;
    load_req = sel && ((cs_fall && !CPHA) || (drive_e && cnt_q == '0 && !cs_fall));
    next_tx  = hold_full ? hold_data : '0;
    rx_next  = {rx_sh[DATA_W-2:0], mosi_s};
  end

  assign consume = load_req && hold_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q     <= CPOL;
      csn_q      <= 1'b1;
      cnt_q      <= '0;
      rx_sh      <= '0;
      tx_sh      <= '0;
      rx_data_q  <= '0;
      rx_valid_q <= 1'b0;
      so_oe_q    <= 1'b0;
      fs_q       <= 1'b0;
      fe_q       <= 1'b0;
    end else begin
      sclk_q     <= sclk_s;
      csn_q      <= csn_s;
      so_oe_q    <= sel;
      fs_q       <= cs_fall;
      fe_q       <= cs_rise;
      rx_valid_q <= 1'b0;
      if (!sel) begin
        cnt_q <= '0;
        rx_sh <= '0;
        tx_sh <= '0;
      end else begin
        if (load_req) tx_sh <= next_tx;
        else if (drive_e) tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
        if (sample_e) begin
          rx_sh <= rx_next;
          if (cnt_q == LAST) begin
            cnt_q      <= '0;
            rx_valid_q <= 1'b1;
            rx_data_q  <= rx_next;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
      end
    end
  end

  assign rx_valid    = rx_valid_q;
  assign rx_data     = rx_data_q;
  assign so_o        = tx_sh[DATA_W-1];
  assign so_oe       = so_oe_q;
  assign frame_start = fs_q;
  assign frame_end   = fe_q;

  assert_strobe_on_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_q |-> (cnt_q == '0));

  assert_abort_clears_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fe_q |-> (cnt_q == '0 && !rx_valid_q));

  assert_release_when_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    csn_s |=> !so_oe_q);

  assert_pulses_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(fs_q && fe_q));
endmodule

// File: rtl/spi_target_frontend.sv
module spi_target_frontend
  import spi_fe_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter bit CPOL = 1'b0,
  parameter bit CPHA = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_clk,
  input  logic              spi_sel_n,
  input  logic              spi_mosi,
  output logic              miso_o,
  output logic              miso_oe,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [DATA_W-1:0] tx_data,
  output logic              frame_start,
  output logic              frame_end
);
  localparam spi_mode_e MODE = spi_mode_e'({CPOL, CPHA});

  logic [2:0]        pins_s;
  logic              consume, hold_full, fe_int;
  logic [DATA_W-1:0] hold_data;

  spi_fe_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL({CPOL, 1'b1, 1'b0})) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({spi_clk, spi_sel_n, spi_mosi}),
    .q(pins_s)
  );

  spi_fe_txbuf #(.DATA_W(DATA_W)) u_txbuf (
    .clk(clk), .rst_n(rst_n),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .consume(consume), .clear(fe_int),
    .hold_full(hold_full), .hold_data(hold_data)
  );

  spi_fe_shifter #(.DATA_W(DATA_W), .CPOL(MODE[1]), .CPHA(MODE[0])) u_shift (
    .clk(clk), .rst_n(rst_n),
    .sclk_s(pins_s[2]), .csn_s(pins_s[1]), .mosi_s(pins_s[0]),
    .hold_full(hold_full), .hold_data(hold_data), .consume(consume),
    .rx_valid(rx_valid), .rx_data(rx_data),
    .so_o(miso_o), .so_oe(miso_oe),
    .frame_start(frame_start), .frame_end(fe_int)
  );

  assign frame_end = fe_int;
endmodule

// File: tb/spi_target_frontend_test.sv
module spi_target_frontend_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 6;
  typedef logic [7:0] bq_t[$];

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [3:0] sclk_v = 4'b1100;
  logic [3:0] csn_v = 4'b1111;
  logic [3:0] txv_v = 4'b0000;
  logic       si = 1'b0;
  logic [7:0] txd = 8'h00;
  logic [3:0] rxv, rdy, so, oe, fs, fe;
  logic [7:0] rxd [4];

  for (genvar m = 0; m < 4; m++) begin : g_mode
    spi_target_frontend #(.DATA_W(8), .CPOL(1'(m / 2)), .CPHA(1'(m % 2))) uut (
      .clk(clk), .rst_n(rst_n),
      .spi_clk(sclk_v[m]), .spi_sel_n(csn_v[m]), .spi_mosi(si),
      .miso_o(so[m]), .miso_oe(oe[m]),
      .rx_valid(rxv[m]), .rx_data(rxd[m]),
      .tx_valid(txv_v[m]), .tx_ready(rdy[m]), .tx_data(txd),
      .frame_start(fs[m]), .frame_end(fe[m])
    );
  end

  int checks = 0;
  int fails = 0;
  logic [7:0] rx_q[$];
  int fs_cnt[4];
  int fe_cnt[4];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Scoreboard monitor: received bytes against the queue filled by the driver.
  always @(negedge clk) begin
    if (rst_n) begin
      for (int m = 0; m < 4; m++) begin
        if (fs[m]) fs_cnt[m]++;
        if (fe[m]) fe_cnt[m]++;
        if (rxv[m]) begin
          if (rx_q.size() == 0) chk(1'b0, "R9 unexpected rx byte", int'(rxd[m]), -1);
          else begin
            logic [7:0] e;
            e = rx_q.pop_front();
            chk(rxd[m] == e, "R1 rx byte", int'(rxd[m]), int'(e));
          end
        end
      end
    end
  end

  task automatic load_tx(input int m, input logic [7:0] b);
    while (!rdy[m]) @(negedge clk);
    txv_v[m] = 1'b1;
    txd = b;
    @(negedge clk);
    txv_v[m] = 1'b0;
  endtask

  // Driver: plays the SPI controller, pushes expected rx bytes, checks MISO.
  task automatic frame(input int m, input bq_t mosi, input bq_t miso_exp, input int h, input int nbits);
    logic p, ph, b;
    logic [7:0] rsh;
    p = 1'(m / 2);
    ph = 1'(m % 2);
    rsh = '0;
    for (int i = 0; i < nbits / 8; i++) rx_q.push_back(mosi[i]);
    @(negedge clk);
    csn_v[m] = 1'b0;
    repeat (2*h) @(negedge clk);
    for (int k = 0; k < nbits; k++) begin
      b = mosi[k/8][7 - (k % 8)];
      if (!ph) begin
        si = b;
        repeat (h) @(negedge clk);
        rsh = {rsh[6:0], so[m]};
        sclk_v[m] = ~p;
        repeat (h) @(negedge clk);
        sclk_v[m] = p;
      end else begin
        sclk_v[m] = ~p;
        si = b;
        repeat (h) @(negedge clk);
        rsh = {rsh[6:0], so[m]};
        sclk_v[m] = p;
        repeat (h) @(negedge clk);
      end
      if (k == 0) chk(oe[m] == 1'b1, "R7 drive while selected", int'(oe[m]), 1);
      if ((k % 8) == 7 && (k / 8) < miso_exp.size())
        chk(rsh == miso_exp[k/8], "R2 R3 R4 miso byte", int'(rsh), int'(miso_exp[k/8]));
    end
    repeat (h) @(negedge clk);
    csn_v[m] = 1'b1;
    repeat (2*h + 4) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int m = 0; m < 4; m++) begin fs_cnt[m] = 0; fe_cnt[m] = 0; end
    repeat (3) @(negedge clk);
    chk(rxv == 4'b0 && oe == 4'b0 && fs == 4'b0 && fe == 4'b0, "R11 outputs in reset", int'({rxv, oe}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(rdy == 4'hF, "R11 ready after reset", int'(rdy), 15);
    chk(oe == 4'b0, "R7 released while idle", int'(oe), 0);

    // R3: every mode, two bytes each way
    for (int m = 0; m < 4; m++) begin
      fs_cnt[m] = 0;
      fe_cnt[m] = 0;
      load_tx(m, 8'hA5 + 8'(m));
      fork
        frame(m, '{8'h3C ^ 8'(m), 8'h96}, '{8'hA5 + 8'(m), 8'h5A}, HALF, 16);
        load_tx(m, 8'h5A);
      join
      chk(fs_cnt[m] == 1, "R8 frame_start once", fs_cnt[m], 1);
      chk(fe_cnt[m] == 1, "R8 frame_end once", fe_cnt[m], 1);
      chk(oe[m] == 1'b0, "R7 released after frame", int'(oe[m]), 0);
    end

    // R6: second byte with nothing loaded
    load_tx(1, 8'hC3);
    frame(1, '{8'h01, 8'h80}, '{8'hC3, 8'h00}, HALF, 16);

    // R5: offer while holding register full is ignored
    load_tx(2, 8'h81);
    @(negedge clk);
    chk(rdy[2] == 1'b0, "R5 ready low when full", int'(rdy[2]), 0);
    txv_v[2] = 1'b1;
    txd = 8'h7E;
    @(negedge clk);
    txv_v[2] = 1'b0;
    frame(2, '{8'hE7}, '{8'h81}, HALF, 8);
    chk(rdy[2] == 1'b1, "R5 ready after byte taken", int'(rdy[2]), 1);

    // R9: abort after three bits, stale byte dropped
    load_tx(0, 8'hF0);
    fork
      frame(0, '{8'hFF}, '{}, HALF, 3);
      load_tx(0, 8'h11);
    join
    chk(rdy[0] == 1'b1, "R9 holding cleared on deselect", int'(rdy[0]), 1);
    frame(0, '{8'h42}, '{8'h00}, HALF, 8);

    // R10: quarter-rate SPI clock
    frame(3, '{8'hD2, 8'h4B}, '{}, 2, 16);

    repeat (10) @(negedge clk);
    chk(rx_q.size() == 0, "R1 R10 all bytes received", rx_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule